// File: doc/BRIEF.md
# Coarse DC Offset Canceller

This block removes a slowly varying DC offset from a stream of signed ADC samples. It sums a fixed window of 16,384 accepted samples and divides the sum by the window length with an arithmetic shift. At the end of each window it replaces a held DC estimate with the result and clears the running sum. Every sample on the data path has the held estimate subtracted from it. The difference is then saturated to the output range, so large inputs cannot wrap.

The block sits in a receive chain ahead of any stage that would scale a residual offset up. Software or a neighbouring block can read the current estimate, and a one-cycle strobe marks each time the estimate is refreshed. When the enable is low, samples pass through unchanged, the window restarts, and the last estimate is kept.

Top module: `dc_offset_canceller`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `est_update` are 0 and `dc_est` is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock cycle.
- R3: With `en` high, each accepted sample produces `out_data` equal to `in_data` minus the `dc_est` that was held when the sample was accepted.
- R4: The difference in R3 is clipped to the range [-32768, 32767] in 16-bit two's complement.
- R5: Only cycles with `in_valid` and `en` both high count toward the window. An update happens on the 16,384th counted sample.
- R6: The new estimate is the floor of the window sum divided by 16,384. This is an arithmetic right shift by 14, so a sum of -1 gives -1.
- R7: The accumulator is cleared after each update, so each window's estimate depends only on that window's samples.
- R8: Any cycle with `en` low passes `in_data` to `out_data` unchanged. It also resets the sample count and the sum to zero, which discards a partial window, and it leaves `dc_est` unchanged.
- R9: `est_update` is high for exactly the one cycle after the clock edge that accepts a window's final sample. `dc_est` shows the new value from that same cycle and is stable whenever `est_update` is low. The final sample itself is still corrected with the old estimate.
- R10: Until the first window completes, the estimate is zero, so accepted samples come out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables correction and integration |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_data | output | 16 | Corrected, saturated signed sample |
| dc_est | output | 16 | Currently held signed DC estimate |
| est_update | output | 1 | One-cycle pulse when `dc_est` is refreshed |

## Verification
The bench runs full windows with gaps in `in_valid`, so a design that counted idle cycles would update too early. One window is built so that its sum is -1. A design that truncated toward zero instead of shifting would report 0 instead of -1. After a large positive estimate is learned, strongly negative and positive samples are driven. A design without clipping would wrap those to the wrong sign. A partial window is cut short by dropping `en` and then followed by a full window. A design that kept the partial sum, or that subtracted while bypassed, would show the wrong estimate or wrong pass-through data.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_WIN_LOG2 = 14;

    // per-cycle control decoded from the window counter
    typedef struct packed {
        logic take;    // sample counts toward the window
        logic last;    // sample closes the window
        logic bypass;  // correction and integration disabled
    } dcc_ctl_t;

    function automatic dcc_ctl_t make_ctl(input logic valid, input logic enable,
                                          input logic cnt_full);
        dcc_ctl_t c;
        c.take   = valid & enable;
        c.last   = valid & enable & cnt_full;
        c.bypass = ~enable;
        return c;
    endfunction

endpackage

// File: rtl/dcc_window_ctr.sv
module dcc_window_ctr
    import dcc_pkg::*;
#(
    parameter int WIN_LOG2 = DEF_WIN_LOG2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     in_valid,
    output dcc_ctl_t ctl
);

    logic [WIN_LOG2-1:0] cnt_q;

    always_comb begin
        ctl = make_ctl(in_valid, en, &cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.bypass) begin
            cnt_q <= '0;
        end else if (ctl.take) begin
            cnt_q <= cnt_q + 1'b1;   // wraps to zero on the closing sample
        end
    end

endmodule

// File: rtl/dcc_integrator.sv
module dcc_integrator
    import dcc_pkg::*;
#(
    parameter int DATA_W   = DEF_SAMPLE_W,
    parameter int WIN_LOG2 = DEF_WIN_LOG2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  dcc_ctl_t                 ctl,
    input  logic signed [DATA_W-1:0] sample,
    output logic signed [DATA_W-1:0] est,
    output logic                     upd
);

    localparam int ACC_W = DATA_W + WIN_LOG2;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum_next;

    always_comb begin
        sum_next = acc_q + {{WIN_LOG2{sample[DATA_W-1]}}, sample};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            est   <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= ctl.last;
            if (ctl.bypass) begin
                acc_q <= '0;
            end else if (ctl.last) begin
                // top bits of the sum = arithmetic shift by WIN_LOG2 (floor)
                est   <= sum_next[ACC_W-1:WIN_LOG2];
                acc_q <= '0;
            end else if (ctl.take) begin
                acc_q <= sum_next;
            end
        end
    end

endmodule

// File: rtl/dcc_subtract.sv
module dcc_subtract
    import dcc_pkg::*;
#(
    parameter int DATA_W = DEF_SAMPLE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic signed [DATA_W-1:0] est,
    input  logic                     bypass,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W:0]   diff;
    logic signed [DATA_W-1:0] clipped;

    always_comb begin
        diff = {in_data[DATA_W-1], in_data}
             - (bypass ? '0 : {est[DATA_W-1], est});
        if (diff[DATA_W] != diff[DATA_W-1]) begin
            clipped = diff[DATA_W] ? NEG_LIM : POS_LIM;
        end else begin
            clipped = diff[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= clipped;
            end
        end
    end

endmodule

// File: rtl/dc_offset_canceller.sv
module dc_offset_canceller
    import dcc_pkg::*;
#(
    parameter int DATA_W   = DEF_SAMPLE_W,
    parameter int WIN_LOG2 = DEF_WIN_LOG2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic signed [DATA_W-1:0] dc_est,
    output logic                     est_update
);

    dcc_ctl_t ctl;

    dcc_window_ctr #(.WIN_LOG2(WIN_LOG2)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .in_valid (in_valid),
        .ctl      (ctl)
    );

    dcc_integrator #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_int (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .sample (in_data),
        .est    (dc_est),
        .upd    (est_update)
    );

    dcc_subtract #(.DATA_W(DATA_W)) u_sub (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .est       (dc_est),
        .bypass    (ctl.bypass),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data,
    input logic signed [DATA_W-1:0] dc_est,
    input logic                     est_update
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !en) |=> (out_data == $past(in_data)));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        est_update |=> !est_update);

    // R9
    est_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !est_update |-> $stable(dc_est));

    // R5
    update_cause_chk: assert property (@(posedge clk) disable iff (rst)
        est_update |-> $past(in_valid && en));

endmodule

bind dc_offset_canceller dcc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .dc_est     (dc_est),
    .est_update (est_update)
);

// File: tb/dc_offset_canceller_test.sv
module dc_offset_canceller_test;

    localparam int WIN = 16384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic signed [15:0] out_data;
    logic signed [15:0] dc_est;
    logic est_update;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference state
    int     m_cnt = 0;
    longint m_sum = 0;
    int     m_est = 0;
    bit     e_valid = 0;
    int     e_data = 0;
    bit     e_upd = 0;

    always #2.5 clk = ~clk;

    dc_offset_canceller uut (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .dc_est(dc_est),
        .est_update(est_update)
    );

    function automatic int clip16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare();
        check(out_valid == e_valid, "R2 out_valid", int'(out_valid), int'(e_valid));
        if (e_valid)
            check(int'(out_data) == e_data, tag, int'(out_data), e_data);
        check(est_update == e_upd, "R9 est_update", int'(est_update), int'(e_upd));
        check(int'(dc_est) == m_est, "R6 dc_est", int'(dc_est), m_est);
    endtask

    task automatic step(input bit v, input bit e, input int d);
        in_valid = v;
        en = e;
        in_data = d[15:0];
        @(posedge clk);
        e_valid = v;
        e_upd = 0;
        if (v) e_data = e ? clip16(d - m_est) : d;
        if (!e) begin
            m_cnt = 0;
            m_sum = 0;
        end else if (v) begin
            m_sum += d;
            m_cnt++;
            if (m_cnt == WIN) begin
                m_est = int'(m_sum >>> 14);
                m_sum = 0;
                m_cnt = 0;
                e_upd = 1;
            end
        end
        @(negedge clk);
        compare();
    endtask

    // feeds n counted samples of value base+noise, with idle gaps
    task automatic run_valid(input int n, input int base, input int noise);
        for (int i = 0; i < n; i++) begin
            if ((i % 7) == 3) step(1'b0, 1'b1, 12345);   // R5 gaps are not counted
            step(1'b1, 1'b1, base + ((noise > 0) ? int'($urandom_range(0, 2*noise)) - noise : 0));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(est_update == 1'b0, "R1 est_update", int'(est_update), 0);
        check(dc_est == 16'sd0, "R1 dc_est", int'(dc_est), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after", int'(out_valid), 0);

        // R10 pass-through before first window, R2 latency with gaps
        tag = "R10 out_data";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, int'($urandom_range(0, 65535)) - 32768);
            if (i % 5 == 0) step(1'b0, 1'b1, 0);
        end

        // R5 R6 R9 first full window with large positive offset
        tag = "R3 out_data";
        run_valid(WIN - 40, 20000, 300);
        check(m_est > 19000, "R6 learned estimate", m_est, 20000);

        // R4 saturation against the learned estimate, R7 new window
        tag = "R4 out_data";
        step(1'b1, 1'b1, -30000);
        step(1'b1, 1'b1, -32768);
        step(1'b1, 1'b1, 32767);
        step(1'b1, 1'b1, 25000);
        tag = "R3 out_data";
        run_valid(WIN - 4, -7, 0);

        // R8 partial window then bypass
        run_valid(5000, 900, 50);
        tag = "R8 bypass out_data";
        for (int i = 0; i < 20; i++)
            step(1'b1, 1'b0, int'($urandom_range(0, 65535)) - 32768);
        step(1'b0, 1'b0, 0);
        check(int'(dc_est) == m_est, "R8 estimate held", int'(dc_est), m_est);

        // R6 floor: window sum of -1 must give -1; R7 fresh window after bypass
        tag = "R7 out_data";
        step(1'b1, 1'b1, -1);
        run_valid(WIN - 1, 0, 0);
        check(m_est == -1, "R6 floor model", m_est, -1);
        tag = "R3 out_data";
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, i * 1000 - 5000);
        step(1'b0, 1'b1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule